// File: doc/BRIEF.md
# Intra-Element Sub-Element Gather

This block rearranges the narrow sub-elements packed inside one wide vector element. A divide code chooses how many equal sub-elements (one, two, four or eight) the element is split into. Each result sub-element takes its value from whichever sub-element of the same source element an index names. The index comes either from the matching lane of a packed index element or from one scalar value that is shared by every lane. An index that names no existing sub-element yields zero. Data never moves from one element into another.

One element is handled per beat. The result is registered. A per-element enable bit decides whether the beat updates the destination register. When it is low, the previous destination value is kept. A pipeline wrapper feeds one element per cycle and collects the permuted element one cycle later.

Top module: `elem_subgather`

## Requirements
- R1: The divide code maps 2'b00, 2'b01, 2'b10 and 2'b11 to 1, 2, 4 and 8 sub-elements. Each sub-element is ELEM_W divided by that count bits wide. Lane j occupies bits [j*W +: W], with lane 0 in the least significant bits.
- R2: In vector-index mode (in_use_scalar=0), the index for result lane j is the full W-bit unsigned value in lane j of in_idx_vec. Result lane j equals source lane idx_j of in_data.
- R3: Any index greater than or equal to the sub-element count writes zero into that result lane. The other lanes are not affected.
- R4: In scalar mode (in_use_scalar=1), in_scalar_idx is taken as an unsigned IDX_W-bit value and compared at full width. The selected source lane is copied into every result lane. An out-of-range scalar index gives an all-zero element.
- R5: With divide code 2'b00, the whole element passes through when its index is zero and becomes zero for any other index.
- R6: A beat with in_valid=1 and in_mask=0 leaves out_data unchanged.
- R7: The result of an enabled beat appears on out_data on the clock edge that samples the beat. out_valid is high exactly in the cycle after a cycle with in_valid high. Cycles with in_valid low leave out_data unchanged.
- R8: A synchronous active-high reset clears out_data and out_valid to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A beat is presented this cycle |
| in_mask | input | 1 | Element enable; 0 keeps the old destination |
| in_use_scalar | input | 1 | 1 selects the shared scalar index |
| in_div_code | input | 2 | Sub-element count code (00=1, 01=2, 10=4, 11=8) |
| in_data | input | ELEM_W | Source element |
| in_idx_vec | input | ELEM_W | Packed per-lane indices |
| in_scalar_idx | input | IDX_W | Shared index used in scalar mode |
| out_valid | output | 1 | A beat was taken in the previous cycle |
| out_data | output | ELEM_W | Registered permuted element |

## Verification
The hardest case to reach is an index that is out of range in one lane but not in its neighbours at the largest sub-element count. Uniform random indices at four-bit lanes land out of range about half the time, and at wider lanes they almost always do. The random stimulus therefore draws each lane index from a small window just above the lane count, so that in-range and out-of-range lanes mix within one element. Directed beats add a scalar index far above the count and mixed patterns at every divide code.

// File: rtl/elem_sg_pkg.sv
package elem_sg_pkg;

    typedef enum logic [1:0] {
        DIV_1 = 2'b00,
        DIV_2 = 2'b01,
        DIV_4 = 2'b10,
        DIV_8 = 2'b11
    } div_code_e;

    typedef struct packed {
        logic      valid;
        logic      enable;
        logic      use_scalar;
        div_code_e code;
    } beat_ctl_t;

    localparam int NUM_CODES = 4;

    function automatic int lanes_of(input int code);
        return 1 << code;
    endfunction

    function automatic int lane_width(input int elem_w, input int code);
        return elem_w >> code;
    endfunction

endpackage

// File: rtl/sgath_lane.sv
module sgath_lane #(
    parameter int ELEM_W = 32,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic [ELEM_W-1:0] src_elem,
    input  logic [LANE_W-1:0] idx_lane,
    input  logic [IDX_W-1:0]  scalar_idx,
    input  logic              use_scalar,
    output logic [LANE_W-1:0] lane_out
);
    localparam int CMP_W = (LANE_W > IDX_W) ? LANE_W : IDX_W;

    logic [CMP_W-1:0] eff_idx;

    always_comb begin
        if (use_scalar) eff_idx = CMP_W'(scalar_idx);
        else            eff_idx = CMP_W'(idx_lane);
    end

    // Any index at or above LANES matches no branch and leaves zero.
    always_comb begin
        lane_out = '0;
        for (int k = 0; k < LANES; k++) begin
            if (eff_idx == CMP_W'(k)) lane_out = src_elem[k*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/sgath_variant.sv
module sgath_variant
    import elem_sg_pkg::*;
#(
    parameter int ELEM_W = 32,
    parameter int CODE   = 2,
    parameter int IDX_W  = 8
) (
    input  logic [ELEM_W-1:0] src_elem,
    input  logic [ELEM_W-1:0] idx_elem,
    input  logic [IDX_W-1:0]  scalar_idx,
    input  logic              use_scalar,
    output logic [ELEM_W-1:0] variant_out
);
    localparam int LANES  = lanes_of(CODE);
    localparam int LANE_W = lane_width(ELEM_W, CODE);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        sgath_lane #(
            .ELEM_W (ELEM_W),
            .LANES  (LANES),
            .LANE_W (LANE_W),
            .IDX_W  (IDX_W)
        ) u_lane (
            .src_elem   (src_elem),
            .idx_lane   (idx_elem[j*LANE_W +: LANE_W]),
            .scalar_idx (scalar_idx),
            .use_scalar (use_scalar),
            .lane_out   (variant_out[j*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/elem_subgather.sv
module elem_subgather
    import elem_sg_pkg::*;
#(
    parameter int ELEM_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_mask,
    input  logic              in_use_scalar,
    input  logic [1:0]        in_div_code,
    input  logic [ELEM_W-1:0] in_data,
    input  logic [ELEM_W-1:0] in_idx_vec,
    input  logic [IDX_W-1:0]  in_scalar_idx,
    output logic              out_valid,
    output logic [ELEM_W-1:0] out_data
);
    localparam int MIN_LANE_W = ELEM_W >> (NUM_CODES - 1);

    initial begin
        if (MIN_LANE_W < 1 || (ELEM_W % (1 << (NUM_CODES - 1))) != 0)
            $error("ELEM_W must split evenly into eight lanes");
        if (IDX_W > 32)
            $error("IDX_W must not exceed 32");
    end

    beat_ctl_t         ctl;
    logic [ELEM_W-1:0] per_code [NUM_CODES];
    logic [ELEM_W-1:0] gathered;

    always_comb begin
        ctl.valid      = in_valid;
        ctl.enable     = in_mask;
        ctl.use_scalar = in_use_scalar;
        ctl.code       = div_code_e'(in_div_code);
    end

    for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
        sgath_variant #(
            .ELEM_W (ELEM_W),
            .CODE   (c),
            .IDX_W  (IDX_W)
        ) u_variant (
            .src_elem    (in_data),
            .idx_elem    (in_idx_vec),
            .scalar_idx  (in_scalar_idx),
            .use_scalar  (ctl.use_scalar),
            .variant_out (per_code[c])
        );
    end

    always_comb begin
        unique case (ctl.code)
            DIV_1:   gathered = per_code[0];
            DIV_2:   gathered = per_code[1];
            DIV_4:   gathered = per_code[2];
            default: gathered = per_code[3];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ctl.valid;
            if (ctl.valid && ctl.enable) out_data <= gathered;
        end
    end

endmodule

// File: rtl/elem_subgather_chk.sv
module elem_subgather_chk #(
    parameter int ELEM_W = 32,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_mask,
    input logic              in_use_scalar,
    input logic [1:0]        in_div_code,
    input logic [ELEM_W-1:0] in_idx_vec,
    input logic [IDX_W-1:0]  in_scalar_idx,
    input logic              out_valid,
    input logic [ELEM_W-1:0] out_data
);
    localparam int H = ELEM_W / 2;

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (out_data == '0 && !out_valid));

    p_valid_follow_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data)));

    p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_mask) |=> $stable(out_data));

    p_single_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mask && !in_use_scalar && in_div_code == 2'b00
         && in_idx_vec != '0) |=> (out_data == '0));

    p_scalar_oob_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mask && in_use_scalar
         && 32'(in_scalar_idx) >= (32'd1 << in_div_code)) |=> (out_data == '0));

    p_scalar_splat_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mask && in_use_scalar && in_div_code == 2'b01)
        |=> (out_data[ELEM_W-1:H] == out_data[H-1:0]));

endmodule

bind elem_subgather elem_subgather_chk #(
    .ELEM_W (ELEM_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_mask       (in_mask),
    .in_use_scalar (in_use_scalar),
    .in_div_code   (in_div_code),
    .in_idx_vec    (in_idx_vec),
    .in_scalar_idx (in_scalar_idx),
    .out_valid     (out_valid),
    .out_data      (out_data)
);

// File: tb/elem_subgather_bench.sv
module elem_subgather_bench;
    localparam int ELEM_W = 32;
    localparam int IDX_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_mask = 1'b0;
    logic              in_use_scalar = 1'b0;
    logic [1:0]        in_div_code = 2'b00;
    logic [ELEM_W-1:0] in_data = '0;
    logic [ELEM_W-1:0] in_idx_vec = '0;
    logic [IDX_W-1:0]  in_scalar_idx = '0;
    logic              out_valid;
    logic [ELEM_W-1:0] out_data;

    int checks = 0;
    int failures = 0;
    logic [ELEM_W-1:0] exp_data = '0;
    bit done = 0;

    always #10 clk = ~clk;

    elem_subgather #(.ELEM_W(ELEM_W), .IDX_W(IDX_W)) u_elem_subgather (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mask(in_mask),
        .in_use_scalar(in_use_scalar), .in_div_code(in_div_code),
        .in_data(in_data), .in_idx_vec(in_idx_vec),
        .in_scalar_idx(in_scalar_idx), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [31:0] model(input logic [31:0] d, input logic [31:0] iv,
                                          input logic [7:0] sc, input bit use_s,
                                          input int code);
        int w = 32 >> code;
        int n = 1 << code;
        longint unsigned m = (64'd1 << w) - 1;
        longint unsigned res = 0;
        for (int j = 0; j < n; j++) begin
            longint unsigned ix = use_s ? longint'(sc) : ((longint'(iv) >> (j*w)) & m);
            if (ix < longint'(n))
                res |= ((longint'(d) >> (int'(ix)*w)) & m) << (j*w);
        end
        return res[31:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic beat(input string tag, input bit v, input bit m, input bit s,
                        input int code, input logic [31:0] d, input logic [31:0] iv,
                        input logic [7:0] sc);
        in_valid = v; in_mask = m; in_use_scalar = s; in_div_code = 2'(code);
        in_data = d; in_idx_vec = iv; in_scalar_idx = sc;
        if (v && m) exp_data = model(d, iv, sc, s, code);
        @(negedge clk);
        check(tag, out_data, exp_data);
        check("R7 out_valid", {31'd0, out_valid}, {31'd0, v});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R8 reset data", out_data, 32'h0);
        check("R8 reset valid", {31'd0, out_valid}, 32'h0);
        rst = 1'b0;

        // R2/R3 mixed in-range and out-of-range lanes at four lanes
        beat("R2 R3 vec d4 a", 1, 1, 0, 2, 32'h0d0e0a0d, 32'h00010902, 8'd0);
        check("R3 exact", out_data, 32'h0d0a000e);
        beat("R2 vec d4 b", 1, 1, 0, 2, 32'h0b0e0e0f, 32'h00020302, 8'd0);
        check("R2 exact", out_data, 32'h0f0e0b0e);
        // R4 broadcast
        beat("R4 splat", 1, 1, 1, 2, 32'h0d0e0a0d, 32'h0, 8'd1);
        check("R4 exact", out_data, 32'h0a0a0a0a);
        beat("R4 oob scalar", 1, 1, 1, 3, 32'h12345678, 32'h0, 8'd200);
        check("R4 zero", out_data, 32'h0);
        // R1 half lanes swap and eight nibble lanes reverse
        beat("R1 d2 swap", 1, 1, 0, 1, 32'hAAAA5555, 32'h00000001, 8'd0);
        check("R1 d2 exact", out_data, 32'h5555AAAA);
        beat("R1 d8 reverse", 1, 1, 0, 3, 32'h76543210, 32'h01234567, 8'd0);
        check("R1 d8 exact", out_data, 32'h01234567);
        // R5 single lane
        beat("R5 pass", 1, 1, 0, 0, 32'hCAFEF00D, 32'h0, 8'd0);
        check("R5 pass exact", out_data, 32'hCAFEF00D);
        beat("R5 zero", 1, 1, 0, 0, 32'hCAFEF00D, 32'h1, 8'd0);
        check("R5 zero exact", out_data, 32'h0);
        // R6 masked beat keeps the old value
        beat("R5 reload", 1, 1, 1, 0, 32'h13572468, 32'h0, 8'd0);
        beat("R6 masked", 1, 0, 1, 2, 32'hFFFFFFFF, 32'h0, 8'd0);
        check("R6 hold", out_data, 32'h13572468);
        // R7 idle beat
        beat("R7 idle", 0, 1, 1, 2, 32'hFFFFFFFF, 32'h0, 8'd0);
        check("R7 hold", out_data, 32'h13572468);

        for (int t = 0; t < 400; t++) begin
            int code = int'($urandom % 4);
            int n = 1 << code;
            int w = 32 >> code;
            bit s = ($urandom % 4) == 0;
            bit v = ($urandom % 8) != 0;
            bit m = ($urandom % 4) != 0;
            logic [31:0] iv = '0;
            logic [7:0] sc = 8'(($urandom % 4 == 0) ? $urandom : $urandom % (n + 2));
            string tag;
            for (int j = 0; j < n; j++) begin
                longint unsigned li = ($urandom % 5 == 0) ? longint'($urandom)
                                                          : longint'($urandom % (n + 2));
                li &= (64'd1 << w) - 1;
                iv |= 32'(li << (j*w));
            end
            if (!v) tag = "R7 rand idle";
            else if (!m) tag = "R6 rand mask";
            else if (code == 0) tag = "R5 rand";
            else if (s) tag = "R4 rand";
            else tag = "R2 R3 rand";
            beat(tag, v, m, s, code, $urandom, iv, sc);
        end

        rst = 1'b1;
        @(negedge clk);
        check("R8 reset again", out_data, 32'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule